// File: doc/BRIEF.md
# Command Ring Fetch Engine

The engine pulls 32-bit command words out of a circular buffer held in memory and hands them, one at a time, to a downstream packet decoder. Software places the buffer by giving a base address and a size selector. It then moves a write index forward as it fills the buffer. Whenever the engine's own read index differs from the write index, the engine runs. It fetches every word from the read index up to the write index, wrapping past the end of the buffer when needed. At the end of the run it sets the read index to the write index it sampled when the run began.

The decoder can divert the stream into a linear indirect buffer. It raises `ib_start` together with a pointer and a word count while it accepts the last word of the packet that asks for the diversion. The engine then fetches exactly that many words from the pointer upward, with no wrap. After that it resumes the ring at the word that follows the diverting packet. Every fetch address carries the top address region of the ring base, whatever pointer produced the lower bits.

Top module: `cmd_ring_fetch`

## Requirements
- R1: The ring holds 2^(25 - `cfg_size_sel`) words, for a selector from 0 to 25. Word offsets advance modulo that count, so offset (count - 1) is followed by offset 0.
- R2: While `rd_idx` equals the current write index, no read is issued and `busy` is low. When they differ, a run delivers the ring words at offsets `rd_idx`, `rd_idx`+1, ... in order, up to but not including the write index, wrapping where the write index lies below the read index.
- R3: In ring mode, address bits 31:29 equal `cfg_base[31:29]` and bits 28:0 equal bits 28:0 of `cfg_base` + 4 × offset. In an indirect run, bits 31:29 still come from `cfg_base`, bits 28:2 come from the indirect pointer plus 4 per word already fetched, and bits 1:0 are zero.
- R4: When a run completes, `rd_idx` takes the write index that was sampled at the start of that run, and `busy` drops in the same cycle.
- R5: A write-index update that arrives while a run is in progress does not change where that run ends. It starts a new run only after the current one completes.
- R6: `wr_max` holds the largest write index written since reset, compared as an unsigned value. It is 0 after reset and never decreases.
- R7: If `ib_start` is high in the cycle a ring word is accepted (`cmd_valid` and `cmd_ready`), the next `ib_len` words come from the indirect buffer with `cmd_indirect` = 1. The ring then resumes at the offset after that accepted word. If that word was the last of the run, the run completes after the indirect words.
- R8: An `ib_start` with `ib_len` = 0 fetches no indirect words, and the ring continues directly.
- R9: `ib_start` is ignored while indirect words are being delivered. There is no nesting, and the word count is unchanged.
- R10: A word offered on `cmd_data` stays valid and unchanged until it is accepted. A read request stays valid with an unchanged address until `mem_req_ready`.
- R11: At most one read is outstanding. No word is offered to the decoder while a read request is being presented.
- R12: After reset, `busy`, `cmd_valid`, `mem_req_valid`, `rd_idx` and `wr_max` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base | input | 32 | Ring base address; top 3 bits give the forced address region |
| cfg_size_sel | input | 5 | Size selector; the ring holds 2^(25 - sel) words |
| wr_idx_valid | input | 1 | Write-index update strobe |
| wr_idx | input | 25 | New write index, in words |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_addr | output | 32 | Byte address of the word to read |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Returned word |
| cmd_valid | output | 1 | Word offered to the decoder |
| cmd_data | output | 32 | Command word |
| cmd_indirect | output | 1 | Word comes from the indirect buffer |
| cmd_ready | input | 1 | Decoder accepts the word |
| ib_start | input | 1 | Divert into an indirect buffer once the current word is accepted |
| ib_addr | input | 32 | Indirect buffer byte pointer |
| ib_len | input | 16 | Indirect buffer length in words |
| busy | output | 1 | A run is in progress |
| rd_idx | output | 25 | Read index, in words |
| wr_max | output | 25 | Largest write index seen |

## Verification
The checks take for granted that the size selector stays within 0 to 25 and that every write index lies inside the ring. Otherwise a run could never meet its end offset. They also take for granted that responses arrive only for an accepted request and that the configuration stays still while `busy` is high. The stimulus changes the base and the size only between resets. It writes indices below the ring word count and answers each accepted read exactly once, after a delay of zero to two idle cycles. It raises `ib_start` only in a cycle in which it also accepts a word.

// File: rtl/cmdf_pkg.sv
package cmdf_pkg;

    // Number of top address bits copied from the ring base onto every fetch.
    localparam int CMDF_REGION_W = 3;

    typedef enum logic [1:0] {
        CMDF_IDLE  = 2'd0,
        CMDF_ISSUE = 2'd1,
        CMDF_WAIT  = 2'd2,
        CMDF_PUSH  = 2'd3
    } cmdf_state_e;

endpackage

// File: rtl/cmdf_ring_geom.sv
// Turns the size selector into a word-offset mask: 2^(IDX_W - sel) words.
module cmdf_ring_geom #(
    parameter int SEL_W = 5,
    parameter int IDX_W = 25
) (
    input  logic [SEL_W-1:0] size_sel,
    output logic [IDX_W-1:0] off_mask
);

    logic [IDX_W:0] span;
    int             shamt;

    always_comb begin
        shamt = IDX_W - int'(size_sel);
        if (shamt <= 0) begin
            span     = (IDX_W+1)'(1);
        end else begin
            span     = (IDX_W+1)'(1) << shamt;
        end
        off_mask = IDX_W'(span - (IDX_W+1)'(1));
    end

endmodule

// File: rtl/cmdf_addr_gen.sv
// Forms the fetch byte address; the base region is imposed on both sources.
module cmdf_addr_gen #(
    parameter int ADDR_W   = 32,
    parameter int IDX_W    = 25,
    parameter int REGION_W = 3
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  ring_off,
    input  logic [ADDR_W-1:0] ib_ptr,
    input  logic              use_ib,
    output logic [ADDR_W-1:0] fetch_addr
);

    localparam int LOW_W = ADDR_W - REGION_W;
    localparam logic [ADDR_W-1:0] LOW_MASK = {{REGION_W{1'b0}}, {LOW_W{1'b1}}};
    localparam logic [ADDR_W-1:0] WORD_ALIGN = ~ADDR_W'(3);

    logic [ADDR_W-1:0] ring_lin;
    logic [ADDR_W-1:0] pick;

    always_comb begin
        ring_lin   = base + (ADDR_W'(ring_off) << 2);
        pick       = use_ib ? (ib_ptr & WORD_ALIGN) : ring_lin;
        fetch_addr = (pick & LOW_MASK) | (base & ~LOW_MASK);
    end

endmodule

// File: rtl/cmdf_wptr_track.sv
// Holds the current write index and the largest index ever written.
module cmdf_wptr_track #(
    parameter int IDX_W = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_valid,
    input  logic [IDX_W-1:0] upd_idx,
    output logic [IDX_W-1:0] cur_idx,
    output logic [IDX_W-1:0] max_idx
);

    typedef struct packed {
        logic [IDX_W-1:0] cur;
        logic [IDX_W-1:0] top;
    } wtrack_t;

    wtrack_t wt_d, wt_q;

    always_comb begin
        wt_d = wt_q;
        if (upd_valid) begin
            wt_d.cur = upd_idx;
            if (upd_idx > wt_q.top) begin
                wt_d.top = upd_idx;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wt_q <= '0;
        end else begin
            wt_q <= wt_d;
        end
    end

    assign cur_idx = wt_q.cur;
    assign max_idx = wt_q.top;

endmodule

// File: rtl/cmd_ring_fetch.sv
module cmd_ring_fetch
    import cmdf_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int SEL_W    = 5,
    parameter int IDX_W    = 25,
    parameter int LEN_W    = 16,
    parameter int REGION_W = CMDF_REGION_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [SEL_W-1:0]  cfg_size_sel,
    input  logic              wr_idx_valid,
    input  logic [IDX_W-1:0]  wr_idx,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              cmd_valid,
    output logic [DATA_W-1:0] cmd_data,
    output logic              cmd_indirect,
    input  logic              cmd_ready,
    input  logic              ib_start,
    input  logic [ADDR_W-1:0] ib_addr,
    input  logic [LEN_W-1:0]  ib_len,
    output logic              busy,
    output logic [IDX_W-1:0]  rd_idx,
    output logic [IDX_W-1:0]  wr_max
);

    localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(4);

    typedef struct packed {
        cmdf_state_e       st;
        logic              ib_mode;
        logic [IDX_W-1:0]  ring_off;
        logic [IDX_W-1:0]  end_off;
        logic [IDX_W-1:0]  rd;
        logic [ADDR_W-1:0] ib_ptr;
        logic [LEN_W-1:0]  ib_left;
        logic [DATA_W-1:0] word;
    } fetch_t;

    fetch_t f_d, f_q;

    logic [IDX_W-1:0] off_mask;
    logic [IDX_W-1:0] wr_cur;
    logic [IDX_W-1:0] ring_next;
    logic             accept;

    cmdf_ring_geom #(
        .SEL_W (SEL_W),
        .IDX_W (IDX_W)
    ) u_geom (
        .size_sel (cfg_size_sel),
        .off_mask (off_mask)
    );

    cmdf_wptr_track #(
        .IDX_W (IDX_W)
    ) u_wtrack (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_valid (wr_idx_valid),
        .upd_idx   (wr_idx),
        .cur_idx   (wr_cur),
        .max_idx   (wr_max)
    );

    cmdf_addr_gen #(
        .ADDR_W   (ADDR_W),
        .IDX_W    (IDX_W),
        .REGION_W (REGION_W)
    ) u_agen (
        .base       (cfg_base),
        .ring_off   (f_q.ring_off),
        .ib_ptr     (f_q.ib_ptr),
        .use_ib     (f_q.ib_mode),
        .fetch_addr (mem_req_addr)
    );

    assign ring_next = (f_q.ring_off + IDX_W'(1)) & off_mask;
    assign accept    = (f_q.st == CMDF_PUSH) && cmd_ready;

    always_comb begin
        f_d = f_q;
        unique case (f_q.st)
            CMDF_IDLE: begin
                if (f_q.rd != wr_cur) begin
                    // Sample the end point; later updates wait for the next run.
                    f_d.end_off  = wr_cur;
                    f_d.ring_off = f_q.rd;
                    f_d.ib_mode  = 1'b0;
                    f_d.st       = CMDF_ISSUE;
                end
            end
            CMDF_ISSUE: begin
                if (mem_req_ready) begin
                    f_d.st = CMDF_WAIT;
                end
            end
            CMDF_WAIT: begin
                if (mem_rsp_valid) begin
                    f_d.word = mem_rsp_data;
                    f_d.st   = CMDF_PUSH;
                end
            end
            CMDF_PUSH: begin
                if (accept) begin
                    f_d.st = CMDF_ISSUE;
                    if (f_q.ib_mode) begin
                        // Indirect word: linear step, bounded by the count.
                        f_d.ib_ptr  = f_q.ib_ptr + WORD_BYTES;
                        f_d.ib_left = f_q.ib_left - LEN_W'(1);
                        if (f_q.ib_left == LEN_W'(1)) begin
                            f_d.ib_mode = 1'b0;
                            if (f_q.ring_off == f_q.end_off) begin
                                f_d.st = CMDF_IDLE;
                                f_d.rd = f_q.end_off;
                            end
                        end
                    end else begin
                        f_d.ring_off = ring_next;
                        if (ib_start && (ib_len != '0)) begin
                            f_d.ib_mode = 1'b1;
                            f_d.ib_ptr  = ib_addr;
                            f_d.ib_left = ib_len;
                        end else if (ring_next == f_q.end_off) begin
                            f_d.st = CMDF_IDLE;
                            f_d.rd = f_q.end_off;
                        end
                    end
                end
            end
            default: begin
                f_d.st = CMDF_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign mem_req_valid = (f_q.st == CMDF_ISSUE);
    assign cmd_valid     = (f_q.st == CMDF_PUSH);
    assign cmd_data      = f_q.word;
    assign cmd_indirect  = f_q.ib_mode;
    assign busy          = (f_q.st != CMDF_IDLE);
    assign rd_idx        = f_q.rd;

endmodule

// File: rtl/cmdf_checker.sv
module cmdf_checker #(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int SEL_W    = 5,
    parameter int IDX_W    = 25,
    parameter int REGION_W = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic [REGION_W-1:0] base_region,
    input logic [SEL_W-1:0]    cfg_size_sel,
    input logic                mem_req_valid,
    input logic                mem_req_ready,
    input logic [ADDR_W-1:0]   mem_req_addr,
    input logic                cmd_valid,
    input logic                cmd_ready,
    input logic [DATA_W-1:0]   cmd_data,
    input logic                cmd_indirect,
    input logic                busy,
    input logic [IDX_W-1:0]    rd_idx,
    input logic [IDX_W-1:0]    wr_max
);

    // R1: selector kept inside the supported range
    a_r1_sel_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cfg_size_sel) <= IDX_W);

    // R3: region bits of every request follow the ring base
    a_r3_addr_region: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> mem_req_addr[ADDR_W-1 -: REGION_W] == base_region);

    // R4: the read index moves only as a run ends
    a_r4_rd_moves_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_idx) |-> !busy);

    // R6: largest write index never decreases
    a_r6_max_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> wr_max >= $past(wr_max));

    // R10: offered word held until accepted
    a_r10_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=>
            (cmd_valid && $stable(cmd_data) && $stable(cmd_indirect)));

    // R10: request held until accepted
    a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr)));

    // R11: no word offered while a request is presented
    a_r11_one_at_a_time: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req_valid && cmd_valid));

    // R2: nothing happens outside a run
    a_r2_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req_valid && !cmd_valid));

endmodule

bind cmd_ring_fetch cmdf_checker #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .SEL_W    (SEL_W),
    .IDX_W    (IDX_W),
    .REGION_W (REGION_W)
) u_cmdf_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .base_region   (cfg_base[ADDR_W-1 -: REGION_W]),
    .cfg_size_sel  (cfg_size_sel),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .cmd_valid     (cmd_valid),
    .cmd_ready     (cmd_ready),
    .cmd_data      (cmd_data),
    .cmd_indirect  (cmd_indirect),
    .busy          (busy),
    .rd_idx        (rd_idx),
    .wr_max        (wr_max)
);

// File: tb/cmd_ring_fetch_bench.sv
module cmd_ring_fetch_bench;

    localparam int IW = 25;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [31:0]   cfg_base = 32'h0;
    logic [4:0]    cfg_size_sel = 5'd22;
    logic          wr_idx_valid = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic          mem_req_valid;
    logic [31:0]   mem_req_addr;
    logic          mem_req_ready;
    logic          mem_rsp_valid;
    logic [31:0]   mem_rsp_data;
    logic          cmd_valid;
    logic [31:0]   cmd_data;
    logic          cmd_indirect;
    logic          cmd_ready;
    logic          ib_start;
    logic [31:0]   ib_addr;
    logic [15:0]   ib_len;
    logic          busy;
    logic [IW-1:0] rd_idx;
    logic [IW-1:0] wr_max;

    always #2.5 clk = ~clk;

    cmd_ring_fetch u_cmd_ring_fetch (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_base      (cfg_base),
        .cfg_size_sel  (cfg_size_sel),
        .wr_idx_valid  (wr_idx_valid),
        .wr_idx        (wr_idx),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .cmd_valid     (cmd_valid),
        .cmd_data      (cmd_data),
        .cmd_indirect  (cmd_indirect),
        .cmd_ready     (cmd_ready),
        .ib_start      (ib_start),
        .ib_addr       (ib_addr),
        .ib_len        (ib_len),
        .busy          (busy),
        .rd_idx        (rd_idx),
        .wr_max        (wr_max)
    );

    int errors = 0;
    int checks = 0;

    logic [32:0] exp_q[$];
    logic [32:0] got_q[$];

    // Consumer / memory model controls
    bit          stall_en = 1'b0;
    int          hs_cnt = 0;
    int          ib_at = -1;
    int          ib_at2 = -1;
    logic [31:0] ib_p = 32'h0;
    logic [15:0] ib_l = 16'd0;
    logic [15:0] lfsr = 16'hACE1;
    bit          pend = 1'b0;
    int          pdelay = 0;
    logic [31:0] paddr = 32'h0;

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return a ^ 32'h5A5A_5A5A;
    endfunction

    function automatic logic [31:0] force_region(input logic [31:0] a);
        return {cfg_base[31:29], a[28:0]};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Memory responder and decoder model, all driven at the falling edge.
    initial begin
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = 32'h0;
        cmd_ready     = 1'b0;
        ib_start      = 1'b0;
        ib_addr       = 32'h0;
        ib_len        = 16'd0;
        forever begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            mem_rsp_valid = 1'b0;
            if (pend) begin
                if (pdelay == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = mem_word(paddr);
                    pend = 1'b0;
                end else begin
                    pdelay--;
                end
            end
            mem_req_ready = stall_en ? lfsr[0] : 1'b1;
            cmd_ready     = stall_en ? (lfsr[1] | lfsr[2]) : 1'b1;
            ib_start      = 1'b0;
            #1;
            if (mem_req_valid && mem_req_ready) begin
                pend   = 1'b1;
                paddr  = mem_req_addr;
                pdelay = stall_en ? (int'(lfsr[4:3]) % 3) : 0;
            end
            if (cmd_valid && cmd_ready) begin
                got_q.push_back({cmd_indirect, cmd_data});
                if (hs_cnt == ib_at || hs_cnt == ib_at2) begin
                    ib_start = 1'b1;
                    ib_addr  = ib_p;
                    ib_len   = ib_l;
                end
                hs_cnt++;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        summary();
        $finish;
    end

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr_write(input int v);
        @(negedge clk);
        wr_idx_valid = 1'b1;
        wr_idx       = IW'(v);
        @(negedge clk);
        wr_idx_valid = 1'b0;
    endtask

    task automatic clear_run();
        exp_q.delete();
        got_q.delete();
        hs_cnt = 0;
        ib_at  = -1;
        ib_at2 = -1;
    endtask

    task automatic wait_done(input int target, input string req);
        int n;
        n = 0;
        while (!(!busy && int'(rd_idx) == target) && n < 4000) begin
            @(negedge clk);
            n++;
        end
        chk(!busy && int'(rd_idx) == target, req, "read index after run",
            64'(rd_idx), 64'(target));
    endtask

    // Expected words of a ring run, with an optional diversion after ring word k.
    task automatic exp_ring(input int from, input int to, input int nwords,
                            input int k, input logic [31:0] ibp, input int len);
        int o;
        int c;
        logic [31:0] ia;
        o = from;
        c = 0;
        while (o != to) begin
            exp_q.push_back({1'b0, mem_word(force_region(cfg_base + 32'(o) * 4))});
            if (c == k) begin
                for (int j = 0; j < len; j++) begin
                    ia = (ibp & ~32'h3) + 32'(j) * 4;
                    exp_q.push_back({1'b1, mem_word(force_region(ia))});
                end
            end
            o = (o + 1) % nwords;
            c++;
        end
    endtask

    task automatic cmp_stream(input string req, input string what);
        bit ok;
        int bad;
        ok  = (got_q.size() == exp_q.size());
        bad = -1;
        if (ok) begin
            for (int i = 0; i < exp_q.size(); i++) begin
                if (got_q[i] != exp_q[i] && bad < 0) begin
                    bad = i;
                end
            end
            ok = (bad < 0);
        end
        if (!ok && bad >= 0) begin
            chk(1'b0, req, $sformatf("%s word %0d", what, bad),
                64'(got_q[bad]), 64'(exp_q[bad]));
        end else begin
            chk(ok, req, {what, " word count"}, 64'(got_q.size()), 64'(exp_q.size()));
        end
    endtask

    task automatic run_to(input int from, input int to, input int nwords,
                          input string req);
        clear_run();
        exp_ring(from, to, nwords, -1, 32'h0, 0);
        wr_write(to);
        wait_done(to, req);
        cmp_stream(req, $sformatf("run %0d->%0d", from, to));
    endtask

    initial begin
        int cur;
        int n;
        // R12: reset state
        cfg_base     = 32'h3FFF_FFF0;
        cfg_size_sel = 5'd22;
        do_reset();
        chk(busy == 1'b0, "R12", "busy after reset", 64'(busy), 0);
        chk(cmd_valid == 1'b0, "R12", "cmd_valid after reset", 64'(cmd_valid), 0);
        chk(mem_req_valid == 1'b0, "R12", "mem_req_valid after reset", 64'(mem_req_valid), 0);
        chk(rd_idx == '0, "R12", "rd_idx after reset", 64'(rd_idx), 0);
        chk(wr_max == '0, "R12", "wr_max after reset", 64'(wr_max), 0);

        // R2: write of the same index starts nothing
        wr_write(0);
        repeat (4) @(negedge clk);
        chk(!busy && !mem_req_valid, "R2", "idle on equal indices", 64'(busy), 0);

        // R1 R2 R3 R4: every (from, to) pair, 8-word ring crossing bit 29, stalls on
        stall_en = 1'b1;
        n   = 8;
        cur = 0;
        for (int a = 0; a < n; a++) begin
            for (int b = 0; b < n; b++) begin
                run_to(cur, a, n, "R2");
                cur = a;
                run_to(cur, b, n, "R3");
                cur = b;
            end
        end
        chk(wr_max == IW'(7), "R6", "max after 8-word sweep", 64'(wr_max), 7);

        // R1: 4-word ring, no stalls, every pair
        stall_en     = 1'b0;
        cfg_base     = 32'hA000_1000;
        cfg_size_sel = 5'd23;
        do_reset();
        n   = 4;
        cur = 0;
        for (int a = 0; a < n; a++) begin
            for (int b = 0; b < n; b++) begin
                run_to(cur, a, n, "R1");
                cur = a;
                run_to(cur, b, n, "R4");
                cur = b;
            end
        end

        // R1: 16-word ring, wrap from 14 to 2
        cfg_size_sel = 5'd21;
        do_reset();
        run_to(0, 14, 16, "R1");
        run_to(14, 2, 16, "R1");

        // R6: maximum kept across a lower write
        cfg_base     = 32'h3FFF_FFF0;
        cfg_size_sel = 5'd22;
        do_reset();
        run_to(0, 6, 8, "R6");
        run_to(6, 2, 8, "R6");
        chk(wr_max == IW'(6), "R6", "max after lower write", 64'(wr_max), 6);

        // R5: update during a run is served after it
        stall_en = 1'b1;
        run_to(2, 1, 8, "R5");
        clear_run();
        exp_ring(1, 5, 8, -1, 32'h0, 0);
        exp_ring(5, 3, 8, -1, 32'h0, 0);
        wr_write(5);
        while (hs_cnt < 1) @(negedge clk);
        chk(busy == 1'b1, "R5", "run still going at update", 64'(busy), 1);
        wr_write(3);
        wait_done(3, "R5");
        cmp_stream("R5", "latched update stream");

        // R7 R3: diversion after ring word 1, length 3, pointer in another region
        stall_en = 1'b0;
        run_to(3, 2, 8, "R7");
        clear_run();
        ib_p  = 32'h6000_0403;
        ib_l  = 16'd3;
        ib_at = 1;
        exp_ring(2, 6, 8, 1, ib_p, 3);
        wr_write(6);
        wait_done(6, "R7");
        cmp_stream("R7", "indirect mid-run");

        // R8: zero-length diversion
        stall_en = 1'b1;
        clear_run();
        ib_p  = 32'h0000_0800;
        ib_l  = 16'd0;
        ib_at = 0;
        exp_ring(6, 0, 8, 0, ib_p, 0);
        wr_write(0);
        wait_done(0, "R8");
        cmp_stream("R8", "zero-length indirect");

        // R7: diversion on the last ring word of the run
        clear_run();
        ib_p  = 32'h1234_5670;
        ib_l  = 16'd2;
        ib_at = 2;
        exp_ring(0, 3, 8, 2, ib_p, 2);
        wr_write(3);
        wait_done(3, "R7");
        cmp_stream("R7", "indirect at run end");

        // R9: wrapping run with diversion; a second request on an indirect word is ignored
        run_to(3, 6, 8, "R9");
        clear_run();
        ib_p   = 32'hE000_0100;
        ib_l   = 16'd2;
        ib_at  = 1;
        ib_at2 = 2;
        exp_ring(6, 2, 8, 1, ib_p, 2);
        wr_write(2);
        wait_done(2, "R9");
        cmp_stream("R9", "nested request ignored");

        summary();
        $finish;
    end

endmodule